// File: doc/BRIEF.md
# Firmware Flash Write-Protect Controller

This block guards the firmware region of a serial flash. It holds a small control register that host software writes and reads. The register has a write-enable bit, a lock bit and a bit that allows writes only in system management mode. The block decides for every flash write request whether it is granted or blocked. Flash reads do not pass through this block.

When software tries to turn on write enable while the lock is already on, the block raises a one-cycle request for a system management interrupt. The interrupt handler can then drive a dedicated clear input that turns write enable off again. With only the lock bit in use, a write issued between the enabling write and the handler's clear still gets through. That gap exists by design and the bench shows it. The mode-gated bit closes the gap: with it set, no write outside system management mode is granted, whatever the timing.

Top module: `fw_wp_ctrl`

## Requirements
- R1: `wrGrant` is combinational: it equals `wrReq & writeEnable & (!smmProtect | inSmm)`. `wrBlock` equals `wrReq & !wrGrant`.
- R2: The register reads back as follows: bit 0 is write enable, bit 1 is lock, bit 5 is SMM-only protect and bit 7 is the violation flag. All other bits read 0, and every bit is 0 after reset. A host write sets bit 0 to the written value.
- R3: A host write with bit 0 = 1 while lock is already 1 makes `smiReq` high for exactly the next cycle, the same cycle in which the new write-enable value first shows.
- R4: A host write with bit 0 = 0, or any host write while lock is 0, never raises `smiReq`.
- R5: `hdlrClr` clears write enable at the next edge. It wins over a host write that sets bit 0 in the same cycle.
- R6: Lock and SMM-only protect stay set until reset. Host writes of 0 to bits 1 and 5 are ignored.
- R7: With lock = 1 and SMM-only = 0, a request made after the enabling write and before the handler clear is granted. After the clear, requests are blocked.
- R8: With SMM-only = 1, no request is granted while `inSmm` = 0. This holds even in the cycle when `smiReq` is high.
- R9: A blocked request sets the violation flag at the next edge. A host write with bit 7 = 1 clears the flag. If a block happens in the same cycle as that write, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regWrData | input | 8 | Host register write data |
| regRdData | output | 8 | Register read-back value |
| hdlrClr | input | 1 | Interrupt handler clear of write enable |
| inSmm | input | 1 | Processor is in system management mode |
| wrReq | input | 1 | Firmware-region flash write request |
| wrGrant | output | 1 | Request allowed |
| wrBlock | output | 1 | Request refused |
| smiReq | output | 1 | One-cycle interrupt request |

## Verification
The bench sweeps all eight combinations of the three control bits, set from reset. For each one it tries every pairing of `inSmm` and `wrReq`, which separates the plain enable path from the mode gate. Timed sequences then cover the following cases:
- The request that falls inside the window between the enabling write and the handler clear. This tells the unprotected setup apart from the protected one.
- A handler clear that coincides with a host write.
- The violation flag being set and cleared, including a set and a clear in the same cycle.

// File: rtl/fw_wp_pkg.sv
package fw_wp_pkg;
  typedef struct packed {
    logic setWe;
    logic clrWe;
    logic setLock;
    logic setSmmP;
    logic clrViol;
  } wpStrobe_t;
endpackage

// File: rtl/fw_wp_ctl.sv
module fw_wp_ctl
  import fw_wp_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int WE_BIT   = 0,
  parameter int LOCK_BIT = 1,
  parameter int SMMP_BIT = 5,
  parameter int VIOL_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             hdlrClr,
  input  logic             lockQ,
  output wpStrobe_t        strb,
  output logic             smiReq
);
  logic smiQ;
  logic wantWe;
  logic unusedData;

  assign unusedData = &{1'b0, regWrData};
  assign wantWe = regWrEn & regWrData[WE_BIT];

  always_comb begin
    strb.clrWe   = hdlrClr | (regWrEn & ~regWrData[WE_BIT]);
    strb.setWe   = wantWe & ~hdlrClr;
    strb.setLock = regWrEn & regWrData[LOCK_BIT];
    strb.setSmmP = regWrEn & regWrData[SMMP_BIT];
    strb.clrViol = regWrEn & regWrData[VIOL_BIT];
  end

  // interrupt raised on any attempt to enable writes under lock
  always_ff @(posedge clk) begin
    if (!rst_n) smiQ <= 1'b0;
    else        smiQ <= wantWe & lockQ;
  end
  assign smiReq = smiQ;

  a_r3_smi_after_locked_set: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regWrData[WE_BIT] && lockQ) |=> smiReq);
  a_r4_smi_needs_attempt: assert property (@(posedge clk) disable iff (!rst_n)
    smiReq |-> $past(regWrEn && regWrData[WE_BIT] && lockQ));
  a_r5_clear_beats_set: assert property (@(posedge clk) disable iff (!rst_n)
    hdlrClr |-> !strb.setWe);
endmodule

// File: rtl/fw_wp_dp.sv
module fw_wp_dp
  import fw_wp_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int WE_BIT   = 0,
  parameter int LOCK_BIT = 1,
  parameter int SMMP_BIT = 5,
  parameter int VIOL_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wpStrobe_t        strb,
  input  logic             inSmm,
  input  logic             wrReq,
  output logic             lockQ,
  output logic [REG_W-1:0] rdData,
  output logic             wrGrant,
  output logic             wrBlock
);
  logic weQ;
  logic smmPQ;
  logic violQ;
  logic modeOk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      weQ   <= 1'b0;
      lockQ <= 1'b0;
      smmPQ <= 1'b0;
      violQ <= 1'b0;
    end else begin
      if (strb.clrWe)      weQ <= 1'b0;
      else if (strb.setWe) weQ <= 1'b1;
      if (strb.setLock) lockQ <= 1'b1;
      if (strb.setSmmP) smmPQ <= 1'b1;
      if (wrBlock)           violQ <= 1'b1;
      else if (strb.clrViol) violQ <= 1'b0;
    end
  end

  assign modeOk  = ~smmPQ | inSmm;
  assign wrGrant = wrReq & weQ & modeOk;
  assign wrBlock = wrReq & ~wrGrant;

  always_comb begin
    rdData           = '0;
    rdData[WE_BIT]   = weQ;
    rdData[LOCK_BIT] = lockQ;
    rdData[SMMP_BIT] = smmPQ;
    rdData[VIOL_BIT] = violQ;
  end

  a_r1_grant_block_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrGrant && wrBlock));
  a_r5_clear_drops_we: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrWe |=> !weQ);
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lockQ |=> lockQ);
  a_r6_smmp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    smmPQ |=> smmPQ);
  a_r8_no_grant_outside_smm: assert property (@(posedge clk) disable iff (!rst_n)
    (smmPQ && !inSmm) |-> !wrGrant);
  a_r9_block_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wrBlock |=> violQ);
endmodule

// File: rtl/fw_wp_ctrl.sv
module fw_wp_ctrl
  import fw_wp_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int WE_BIT   = 0,
  parameter int LOCK_BIT = 1,
  parameter int SMMP_BIT = 5,
  parameter int VIOL_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             hdlrClr,
  input  logic             inSmm,
  input  logic             wrReq,
  output logic             wrGrant,
  output logic             wrBlock,
  output logic             smiReq
);
  wpStrobe_t strb;
  logic      lockQ;

  fw_wp_ctl #(
    .REG_W(REG_W), .WE_BIT(WE_BIT), .LOCK_BIT(LOCK_BIT),
    .SMMP_BIT(SMMP_BIT), .VIOL_BIT(VIOL_BIT)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .hdlrClr(hdlrClr), .lockQ(lockQ), .strb(strb), .smiReq(smiReq)
  );

  fw_wp_dp #(
    .REG_W(REG_W), .WE_BIT(WE_BIT), .LOCK_BIT(LOCK_BIT),
    .SMMP_BIT(SMMP_BIT), .VIOL_BIT(VIOL_BIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .inSmm(inSmm), .wrReq(wrReq),
    .lockQ(lockQ), .rdData(regRdData), .wrGrant(wrGrant), .wrBlock(wrBlock)
  );
endmodule

// File: tb/fw_wp_ctrl_test.sv
module fw_wp_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       hdlrClr = 1'b0;
  logic       inSmm = 1'b0;
  logic       wrReq = 1'b0;
  logic       wrGrant, wrBlock, smiReq;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fw_wp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .hdlrClr(hdlrClr), .inSmm(inSmm), .wrReq(wrReq),
    .wrGrant(wrGrant), .wrBlock(wrBlock), .smiReq(smiReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic resetDut();
    rst_n = 1'b0; regWrEn = 1'b0; regWrData = 8'h00;
    hdlrClr = 1'b0; inSmm = 1'b0; wrReq = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step();
  endtask

  task automatic hostWr(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 8'h00;
    #1;
  endtask

  initial begin
    resetDut();
    check("R2 reset read", regRdData, 8'h00);
    check("R4 reset smi", {7'd0, smiReq}, 8'h00);
    check("R1 reset grant", {7'd0, wrGrant}, 8'h00);

    // sweep of every control configuration from reset
    for (int cfg = 0; cfg < 8; cfg++) begin
      logic we, lk, sp;
      we = cfg[0]; lk = cfg[1]; sp = cfg[2];
      resetDut();
      hostWr({2'b00, sp, 3'b000, lk, we});
      check("R4 no smi while unlocked", {7'd0, smiReq}, 8'h00);
      check("R2 read layout", regRdData, {2'b00, sp, 3'b000, lk, we});
      for (int s = 0; s < 2; s++) begin
        for (int r = 0; r < 2; r++) begin
          logic eg;
          inSmm = s[0]; wrReq = r[0];
          #1;
          eg = r[0] & we & (~sp | s[0]);
          check("R1 grant", {7'd0, wrGrant}, {7'd0, eg});
          check("R1 block", {7'd0, wrBlock}, {7'd0, r[0] & ~eg});
        end
      end
      wrReq = 1'b0; inSmm = 1'b0;
    end

    // R3 / R4 interrupt pulse
    resetDut();
    hostWr(8'h02);
    check("R4 lock-setting write no smi", {7'd0, smiReq}, 8'h00);
    hostWr(8'h01);
    check("R3 smi pulse high", {7'd0, smiReq}, 8'h01);
    check("R3 we visible with smi", regRdData, 8'h03);
    step();
    check("R3 smi single cycle", {7'd0, smiReq}, 8'h00);
    hostWr(8'h00);
    check("R4 clearing write no smi", {7'd0, smiReq}, 8'h00);
    check("R6 lock ignores write of 0", regRdData, 8'h02);

    // R7 vulnerable window with lock only
    hostWr(8'h01);
    wrReq = 1'b1; #1;
    check("R7 write granted inside window", {7'd0, wrGrant}, 8'h01);
    wrReq = 1'b0;
    hdlrClr = 1'b1; step(); hdlrClr = 1'b0;
    check("R5 handler clears we", regRdData, 8'h02);
    wrReq = 1'b1; #1;
    check("R7 blocked after clear", {7'd0, wrBlock}, 8'h01);
    step(); wrReq = 1'b0;
    check("R9 block sets flag", regRdData, 8'h82);
    hostWr(8'h80);
    check("R9 write-one clears flag", regRdData, 8'h02);
    regWrEn = 1'b1; regWrData = 8'h80; wrReq = 1'b1;
    step();
    regWrEn = 1'b0; regWrData = 8'h00; wrReq = 1'b0;
    check("R9 set wins over clear", regRdData, 8'h82);
    hostWr(8'h80);

    // R5 priority of handler clear over host set
    hdlrClr = 1'b1;
    hostWr(8'h01);
    hdlrClr = 1'b0;
    check("R5 handler clear wins", regRdData & 8'h01, 8'h00);

    // R8 protected configuration
    resetDut();
    hostWr(8'h22);
    check("R2 protected config read", regRdData, 8'h22);
    hostWr(8'h21);
    check("R3 smi on locked enable", {7'd0, smiReq}, 8'h01);
    wrReq = 1'b1; inSmm = 1'b0; #1;
    check("R8 no grant outside smm in smi cycle", {7'd0, wrGrant}, 8'h00);
    inSmm = 1'b1; #1;
    check("R8 grant inside smm", {7'd0, wrGrant}, 8'h01);
    wrReq = 1'b0; inSmm = 1'b0;
    hostWr(8'h01);
    check("R6 smm-only ignores write of 0", regRdData & 8'h22, 8'h22);
    wrReq = 1'b1; #1;
    check("R8 still blocked outside smm", {7'd0, wrBlock}, 8'h01);
    wrReq = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule